// File: doc/BRIEF.md
# TLB Invalidate Request Decoder

This block takes one translation-invalidate command at a time and reduces it to exactly one action. The command carries a 64-bit address/selector operand, a two-bit invalidation-control code, a process-scope bit, a radix bit, a local/broadcast flag, the current hypervisor-mode bit and a host-radix control bit. The decoder answers with one of four outcomes: an invalid-form indication for the exception logic, a no-operation, a single-page flush (with an aligned page address and a local/broadcast qualifier), or a full flush that raises sticky pending-flush flags.

Commands enter through a valid/ready handshake. One clock edge after acceptance the block presents a single-cycle result pulse carrying the action code. While that pulse is high the block refuses a new command. The pending flags stay set until a separate acknowledge input clears them. The TLB arrays, the exception path and the broadcast network sit outside this block.

The checks run in a fixed priority order. A full-flush fallback covers every case that is valid but not supported as a page operation.

Top module: `tlbi_cmd_decoder`

## Requirements
- R1: The effective radix bit equals `cmd_radix` when `hv_mode` is 1, and equals `host_radix` otherwise. When the effective radix bit is 0, the result is a full flush whatever the other fields hold.
- R2: With effective radix 1, the command is an invalid form (action code 1) in any of three cases: the control code is 3; the control code is 1 or 2 while the selector RB[11:10] is 0; or `cmd_prs` is 0 while the selector is 1.
- R3: A command with control code 1 that passes R2 gives action code 1 when `cmd_local` is 1 and the set field RB[23:12] is nonzero. In every other case it gives the no-op action code 2.
- R4: A command that passes R2 and R3 with a selector RB[11:10] other than 0 gives a full flush (action code 4).
- R5: With control code 0, `cmd_prs` 1 and selector 0, a nonzero quadrant field RB[63:62] gives a full flush.
- R6: The page-size code RB[7:5] sets the page-offset mask: 0 gives 0xFFF, 5 gives 0xFFFF, 1 gives 0x1FFFFF and 2 gives 0x3FFFFFFF. Any other code gives action code 1.
- R7: A page flush (action code 3) outputs RB with bits 11:0 cleared and the page-offset mask bits cleared. `res_local` repeats `cmd_local`, where 1 means local and 0 means broadcast.
- R8: A full flush sets `pend_local`, and also sets `pend_global` when `cmd_local` is 0. Both flags hold until `pend_ack` is sampled high. A full flush registered on the same edge as an acknowledge leaves its flags set.
- R9: A command is accepted on an edge where `cmd_valid` and `cmd_ready` are both high. `res_valid` is high for exactly the one cycle after that edge, and `cmd_ready` is low during that cycle. Action code 0 with a zero address shows whenever no result is present.
- R10: After reset, `res_valid`, both pending flags, `res_action` and `res_page_addr` are 0 and `cmd_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_rb | input | 64 | Address/selector operand |
| cmd_ric | input | 2 | Invalidation-control code |
| cmd_prs | input | 1 | Process-scoped request |
| cmd_radix | input | 1 | Radix bit from the command |
| cmd_local | input | 1 | 1 = local only, 0 = broadcast |
| hv_mode | input | 1 | Hypervisor mode |
| host_radix | input | 1 | Host radix control bit |
| res_valid | output | 1 | One-cycle result pulse |
| res_action | output | 3 | 0 none, 1 invalid, 2 no-op, 3 page, 4 full |
| res_page_addr | output | 64 | Aligned page address for action 3 |
| res_local | output | 1 | Local qualifier of the page flush |
| pend_local | output | 1 | Sticky local full-flush pending |
| pend_global | output | 1 | Sticky global full-flush pending |
| pend_ack | input | 1 | Clears both pending flags |

## Verification
A wrong priority in the check chain appears as the wrong action code on the very next result pulse. A bad page-size mask appears as a misaligned page address in that same pulse. Pending-flag faults stay visible on the flag ports for as long as the state lasts: a flag that fails to set, or one that survives an acknowledge, can be seen one edge after the event. The stimulus mixes random field values with directed cases at each priority boundary, so each rung of the chain decides the result at least once.

// File: rtl/tlbi_pkg.sv
package tlbi_pkg;
   typedef enum logic [2:0] {
      ACT_IDLE    = 3'd0,
      ACT_INVALID = 3'd1,
      ACT_NOP     = 3'd2,
      ACT_PAGE    = 3'd3,
      ACT_FULL    = 3'd4
   } tlbi_act_e;

   localparam logic [1:0] SEL_VA   = 2'd0;
   localparam logic [1:0] SEL_PID  = 2'd1;
   localparam logic [1:0] SEL_LPID = 2'd2;
   localparam logic [1:0] SEL_ALL  = 2'd3;

   localparam logic [1:0] CTL_TLB  = 2'd0;
   localparam logic [1:0] CTL_PWC  = 2'd1;
   localparam logic [1:0] CTL_BOTH = 2'd2;
   localparam logic [1:0] CTL_GRP  = 2'd3;
endpackage

// File: rtl/tlbi_page_mask.sv
module tlbi_page_mask #(
   parameter int RB_W = 64,
   parameter int AP_W = 3
) (
   input  logic [AP_W-1:0] ap_code,
   output logic            ap_ok,
   output logic [RB_W-1:0] offs_mask
);
   localparam int SH_W = 8;

   if (RB_W > 255) begin : g_bad_width
      $error("tlbi_page_mask: RB_W too large");
   end
   if (AP_W < 3) begin : g_bad_ap
      $error("tlbi_page_mask: AP_W must hold codes up to 5");
   end

   logic [SH_W-1:0] shift;

   always_comb begin
      ap_ok = 1'b1;
      shift = '0;
      case (ap_code)
         AP_W'(0): shift = SH_W'(12);
         AP_W'(5): shift = SH_W'(16);
         AP_W'(1): shift = SH_W'(21);
         AP_W'(2): shift = SH_W'(30);
         default: ap_ok = 1'b0;
      endcase
   end

   for (genvar b = 0; b < RB_W; b++) begin : g_bit
      localparam logic [SH_W-1:0] BIDX = SH_W'(b);
      assign offs_mask[b] = ap_ok && (BIDX < shift);
   end
endmodule

// File: rtl/tlbi_check_chain.sv
module tlbi_check_chain
   import tlbi_pkg::*;
#(
   parameter int RB_W     = 64,
   parameter int SEL_LSB  = 10,
   parameter int SET_LSB  = 12,
   parameter int SET_W    = 12,
   parameter int AP_LSB   = 5,
   parameter int AP_W     = 3,
   parameter int EPN_LSB  = 12,
   parameter int QUAD_W   = 2
) (
   input  logic [RB_W-1:0] rb,
   input  logic [1:0]      ric,
   input  logic            prs,
   input  logic            radix,
   input  logic            is_local,
   input  logic            hv,
   input  logic            host_radix,
   output tlbi_act_e       act,
   output logic [RB_W-1:0] page_addr
);
   localparam logic [RB_W-1:0] EPN_MASK = {RB_W{1'b1}} << EPN_LSB;

   if (SET_LSB + SET_W > RB_W || SEL_LSB + 2 > RB_W || AP_LSB + AP_W > RB_W) begin : g_bad_fields
      $error("tlbi_check_chain: field outside operand");
   end
   if (QUAD_W < 1 || QUAD_W > RB_W) begin : g_bad_quad
      $error("tlbi_check_chain: bad quadrant width");
   end

   logic              eff_radix;
   logic [1:0]        sel;
   logic [SET_W-1:0]  set_f;
   logic [AP_W-1:0]   ap_f;
   logic [QUAD_W-1:0] quad;
   logic              bad_form;
   logic              ap_ok;
   logic [RB_W-1:0]   offs_mask;

   assign eff_radix = hv ? radix : host_radix;
   assign sel       = rb[SEL_LSB +: 2];
   assign set_f     = rb[SET_LSB +: SET_W];
   assign ap_f      = rb[AP_LSB +: AP_W];
   assign quad      = rb[RB_W-1 -: QUAD_W];

   assign bad_form = (ric == CTL_GRP)
                  || (((ric == CTL_PWC) || (ric == CTL_BOTH)) && (sel == SEL_VA))
                  || (!prs && (sel == SEL_PID));

   tlbi_page_mask #(.RB_W(RB_W), .AP_W(AP_W)) u_mask (
      .ap_code  (ap_f),
      .ap_ok    (ap_ok),
      .offs_mask(offs_mask)
   );

   always_comb begin
      if (!eff_radix) begin
         act = ACT_FULL;
      end else if (bad_form) begin
         act = ACT_INVALID;
      end else if (ric == CTL_PWC) begin
         act = (is_local && (set_f != '0)) ? ACT_INVALID : ACT_NOP;
      end else if (sel != SEL_VA) begin
         act = ACT_FULL;
      end else if ((ric == CTL_TLB) && prs && (quad != '0)) begin
         act = ACT_FULL;
      end else if (!ap_ok) begin
         act = ACT_INVALID;
      end else begin
         act = ACT_PAGE;
      end
   end

   assign page_addr = (act == ACT_PAGE) ? (rb & EPN_MASK & ~offs_mask) : '0;
endmodule

// File: rtl/tlbi_pending_flags.sv
module tlbi_pending_flags #(
   parameter bit SET_OVER_ACK = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_local,
   input  logic set_global,
   input  logic ack,
   output logic pend_local,
   output logic pend_global
);
   logic nxt_local;
   logic nxt_global;

   if (SET_OVER_ACK) begin : g_set_wins
      assign nxt_local  = set_local  | (pend_local  & ~ack);
      assign nxt_global = set_global | (pend_global & ~ack);
   end else begin : g_ack_wins
      assign nxt_local  = ~ack & (set_local  | pend_local);
      assign nxt_global = ~ack & (set_global | pend_global);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_local  <= 1'b0;
         pend_global <= 1'b0;
      end else begin
         pend_local  <= nxt_local;
         pend_global <= nxt_global;
      end
   end
endmodule

// File: rtl/tlbi_cmd_decoder.sv
module tlbi_cmd_decoder
   import tlbi_pkg::*;
#(
   parameter int RB_W    = 64,
   parameter int SEL_LSB = 10,
   parameter int SET_LSB = 12,
   parameter int SET_W   = 12,
   parameter int AP_LSB  = 5,
   parameter int AP_W    = 3,
   parameter int EPN_LSB = 12,
   parameter int QUAD_W  = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cmd_valid,
   output logic            cmd_ready,
   input  logic [RB_W-1:0] cmd_rb,
   input  logic [1:0]      cmd_ric,
   input  logic            cmd_prs,
   input  logic            cmd_radix,
   input  logic            cmd_local,
   input  logic            hv_mode,
   input  logic            host_radix,
   output logic            res_valid,
   output logic [2:0]      res_action,
   output logic [RB_W-1:0] res_page_addr,
   output logic            res_local,
   output logic            pend_local,
   output logic            pend_global,
   input  logic            pend_ack
);
   if (EPN_LSB < 1 || EPN_LSB >= RB_W) begin : g_bad_epn
      $error("tlbi_cmd_decoder: EPN_LSB out of range");
   end

   tlbi_act_e       dec_act;
   logic [RB_W-1:0] dec_addr;
   logic            accept;
   logic            full_hit;

   tlbi_check_chain #(
      .RB_W(RB_W), .SEL_LSB(SEL_LSB), .SET_LSB(SET_LSB), .SET_W(SET_W),
      .AP_LSB(AP_LSB), .AP_W(AP_W), .EPN_LSB(EPN_LSB), .QUAD_W(QUAD_W)
   ) u_chain (
      .rb        (cmd_rb),
      .ric       (cmd_ric),
      .prs       (cmd_prs),
      .radix     (cmd_radix),
      .is_local  (cmd_local),
      .hv        (hv_mode),
      .host_radix(host_radix),
      .act       (dec_act),
      .page_addr (dec_addr)
   );

   assign cmd_ready = ~res_valid;
   assign accept    = cmd_valid & cmd_ready;
   assign full_hit  = accept & (dec_act == ACT_FULL);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid     <= 1'b0;
         res_action    <= ACT_IDLE;
         res_page_addr <= '0;
         res_local     <= 1'b0;
      end else if (accept) begin
         res_valid     <= 1'b1;
         res_action    <= dec_act;
         res_page_addr <= dec_addr;
         res_local     <= cmd_local;
      end else begin
         res_valid     <= 1'b0;
         res_action    <= ACT_IDLE;
         res_page_addr <= '0;
         res_local     <= 1'b0;
      end
   end

   tlbi_pending_flags #(.SET_OVER_ACK(1'b1)) u_pend (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_local  (full_hit),
      .set_global (full_hit & ~cmd_local),
      .ack        (pend_ack),
      .pend_local (pend_local),
      .pend_global(pend_global)
   );
endmodule

// File: rtl/tlbi_cmd_decoder_chk.sv
module tlbi_cmd_decoder_chk #(
   parameter int RB_W = 64
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cmd_valid,
   input logic            cmd_ready,
   input logic            cmd_local,
   input logic            res_valid,
   input logic [2:0]      res_action,
   input logic [RB_W-1:0] res_page_addr,
   input logic            pend_local,
   input logic            pend_global,
   input logic            pend_ack
);
   AST_ACCEPT_GIVES_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready) |=> res_valid); // R9
   AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid); // R9
   AST_BUSY_DURING_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> !cmd_ready); // R9
   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |-> (res_action == 3'd0 && res_page_addr == '0)); // R9
   AST_PAGE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_action == 3'd3) |-> (res_page_addr[11:0] == 12'd0)); // R7
   AST_FULL_SETS_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_action == 3'd4) |-> pend_local); // R8
   AST_GLOBAL_NEEDS_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
      pend_global |-> pend_local); // R8
   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(pend_ack) && !(res_valid && res_action == 3'd4)) |-> (!pend_local && !pend_global)); // R8
   AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_local && !pend_ack) |=> pend_local); // R8
endmodule

bind tlbi_cmd_decoder tlbi_cmd_decoder_chk #(.RB_W(RB_W)) u_chk (.*);

// File: tb/tlbi_cmd_decoder_tb.sv
module tlbi_cmd_decoder_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic [63:0] cmd_rb = '0;
   logic [1:0]  cmd_ric = '0;
   logic        cmd_prs = 1'b0;
   logic        cmd_radix = 1'b0;
   logic        cmd_local = 1'b0;
   logic        hv_mode = 1'b0;
   logic        host_radix = 1'b0;
   logic        res_valid;
   logic [2:0]  res_action;
   logic [63:0] res_page_addr;
   logic        res_local;
   logic        pend_local;
   logic        pend_global;
   logic        pend_ack = 1'b0;

   int errors = 0;
   int checks = 0;
   int cycles = 0;
   bit exp_pl = 1'b0;
   bit exp_pg = 1'b0;

   always #10 clk = ~clk;

   tlbi_cmd_decoder u_dut (.*);

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Expected outcome written from the requirement text
   function automatic void model(input logic [63:0] rb, input logic [1:0] ric,
                                 input logic prs, input logic r, input logic loc,
                                 input logic hv, input logic hr,
                                 output logic [2:0] act, output logic [63:0] addr);
      logic        er;
      logic [1:0]  sel;
      logic [63:0] m;
      er   = hv ? r : hr;
      sel  = rb[11:10];
      addr = '0;
      m    = '0;
      if (!er) act = 3'd4;
      else if (ric == 2'd3 || (ric != 2'd0 && sel == 2'd0) || (!prs && sel == 2'd1)) act = 3'd1;
      else if (ric == 2'd1) act = (loc && rb[23:12] != 12'd0) ? 3'd1 : 3'd2;
      else if (sel != 2'd0) act = 3'd4;
      else if (ric == 2'd0 && prs && rb[63:62] != 2'd0) act = 3'd4;
      else begin
         case (rb[7:5])
            3'd0: m = 64'hFFF;
            3'd5: m = 64'hFFFF;
            3'd1: m = 64'h1F_FFFF;
            3'd2: m = 64'h3FFF_FFFF;
            default: m = '1;
         endcase
         if (m == '1) act = 3'd1;
         else begin
            act  = 3'd3;
            addr = rb & ~64'hFFF & ~m;
         end
      end
   endfunction

   task automatic send(input string tag, input logic [63:0] rb, input logic [1:0] ric,
                       input logic prs, input logic r, input logic loc,
                       input logic hv, input logic hr, input logic ack);
      logic [2:0]  ea;
      logic [63:0] ead;
      model(rb, ric, prs, r, loc, hv, hr, ea, ead);
      @(negedge clk);
      chk({tag, " R9 ready before"}, 64'(cmd_ready), 64'd1);
      cmd_valid = 1'b1; cmd_rb = rb; cmd_ric = ric; cmd_prs = prs;
      cmd_radix = r; cmd_local = loc; hv_mode = hv; host_radix = hr; pend_ack = ack;
      @(negedge clk);
      cmd_valid = 1'b0; pend_ack = 1'b0;
      if (ack) begin exp_pl = 1'b0; exp_pg = 1'b0; end
      if (ea == 3'd4) begin exp_pl = 1'b1; if (!loc) exp_pg = 1'b1; end
      chk({tag, " R9 pulse"}, 64'(res_valid), 64'd1);
      chk({tag, " R9 busy"}, 64'(cmd_ready), 64'd0);
      chk({tag, " action"}, 64'(res_action), 64'(ea));
      if (ea == 3'd3) begin
         chk({tag, " R7 addr"}, res_page_addr, ead);
         chk({tag, " R7 local"}, 64'(res_local), 64'(loc));
      end
      chk({tag, " R8 pend_local"}, 64'(pend_local), 64'(exp_pl));
      chk({tag, " R8 pend_global"}, 64'(pend_global), 64'(exp_pg));
      @(negedge clk);
      chk({tag, " R9 pulse ends"}, 64'(res_valid), 64'd0);
      chk({tag, " R9 idle action"}, 64'(res_action), 64'd0);
   endtask

   task automatic do_ack();
      @(negedge clk);
      pend_ack = 1'b1;
      @(negedge clk);
      pend_ack = 1'b0;
      exp_pl = 1'b0; exp_pg = 1'b0;
      chk("R8 ack clears local", 64'(pend_local), 64'd0);
      chk("R8 ack clears global", 64'(pend_global), 64'd0);
   endtask

   initial begin
      int unsigned seed_init;
      seed_init = $urandom(32'd20240611);
      repeat (3) @(negedge clk);
      // R10 reset state
      chk("R10 res_valid", 64'(res_valid), 64'd0);
      chk("R10 ready", 64'(cmd_ready), 64'd1);
      chk("R10 action", 64'(res_action), 64'd0);
      chk("R10 addr", res_page_addr, 64'd0);
      chk("R10 pend_local", 64'(pend_local), 64'd0);
      chk("R10 pend_global", 64'(pend_global), 64'd0);
      rst_n = 1'b1;

      // R1: effective radix 0 in hv mode despite host bit, and via host bit
      send("R1 hv r=0", 64'h0000_0000_0000_0000, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
      chk("R1 local full no global", 64'(pend_global), 64'd0);
      do_ack();
      send("R1 host=0 group", 64'h0, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
      do_ack();
      send("R1 host=1 page", 64'h1234_5678_9ABC_D0E0 & ~64'hE0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
      // R2 invalid forms
      send("R2 ric3", 64'h0, 2'd3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
      send("R2 ric2 va", 64'h0, 2'd2, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
      send("R2 prs0 pid", 64'h400, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
      // R3 page-walk control
      send("R3 local set", 64'h0000_0000_0000_1400, 2'd1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
      send("R3 global set nop", 64'h0000_0000_0000_1400, 2'd1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
      send("R3 local zero set nop", 64'h0000_0000_0000_0800, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
      // R4 selector fallback
      send("R4 sel all", 64'hC00, 2'd2, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
      do_ack();
      // R5 quadrant
      send("R5 quad", 64'h4000_0000_0000_0000, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
      do_ack();
      send("R5 quad prs0 page", 64'h4000_0000_0000_0000, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
      // R6 page sizes
      send("R6 ap0", 64'hFFFF_FFFF_FFFF_F000, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
      send("R6 ap5", 64'h3FFF_FFFF_FFFF_F0A0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
      send("R6 ap1", 64'h3FFF_FFFF_FFFF_F020, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
      send("R6 ap2", 64'h3FFF_FFFF_FFFF_F040, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
      send("R6 ap7 invalid", 64'h0000_0000_0000_00E0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
      // R8 set wins over ack on the same edge
      send("R8 full with ack", 64'h0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
      @(negedge clk);
      chk("R8 sticky local", 64'(pend_local), 64'd1);
      chk("R8 sticky global", 64'(pend_global), 64'd1);
      do_ack();

      // Random mix
      for (int i = 0; i < 400; i++) begin
         logic [63:0] rb;
         rb = {$urandom, $urandom};
         if ($urandom_range(0, 1) == 0) rb[63:62] = 2'd0;
         if ($urandom_range(0, 1) == 0) rb[23:12] = 12'd0;
         send("R1..R8 random", rb, 2'($urandom_range(0, 3)), 1'($urandom), 1'($urandom),
              1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom_range(0, 5) == 0));
         if ($urandom_range(0, 7) == 0) do_ack();
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule